// File: doc/BRIEF.md
# Timer Clock Source Selector

This block produces the count-enable strobe for each of several timer/counters from one shared prescaler. The prescaler is a free-running 10-bit counter in the peripheral clock domain. It derives seven divided strobes from that count, at ratios 1, 2, 4, 8, 64, 256 and 1024. Each timer has a 4-bit select field. The field either holds the timer stopped, or picks one prescaler strobe, or picks one of eight event strobes as the timer's tick.

The output `tick_o[t]` is a combinational, single-cycle enable for timer `t`'s counter. Because all timers share one prescaler, timers that select the same ratio tick in the same cycles. A selected event input passes straight through in the cycle it arrives. An event input must be selected whenever a timer is driven by event actions.

Top module: `tmr_clk_sel`

## Requirements
- R1: A select value of 0 (stopped) holds that timer's `tick_o` low in every cycle, whatever the event inputs do.
- R2: Select value 1 (divide by 1) drives that timer's `tick_o` high in every cycle out of reset.
- R3: Select values 2 to 7 pick divide ratios D of 2, 4, 8, 64, 256 and 1024 in that order. `tick_o` is high exactly in the cycles where the prescaler count has all of its low log2(D) bits set. The prescaler count is the number of rising edges since reset release, modulo 1024.
- R4: The prescaler is common to all timers and runs freely. No select change on any timer shifts its phase.
- R5: Select values 8 to 15 pick event input `evt_i[sel-8]`. `tick_o` equals that input in the same cycle, with no register in the path.
- R6: Event inputs that a timer does not select have no effect on that timer's `tick_o`.
- R7: Each timer t reads only its own field `sel_i[4t+3:4t]`. Timers with different fields produce independent ticks in the same cycle.
- R8: While `rst_ni` is low, every `tick_o` bit is low. After release the prescaler restarts from 0, so the first divide-by-1024 tick falls 1023 cycles after release.
- R9: Over any 1024-cycle window aligned to the prescaler, divide ratio D yields exactly 1024/D ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 4*N_TIMERS | Per-timer clock select fields, timer t at bits 4t+3:4t |
| evt_i | input | 8 | Event channel strobes, one cycle each |
| tick_o | output | N_TIMERS | Per-timer count-enable strobe |

## Verification
A tap strobe and an event strobe can fall in the same cycle on different timers. A select change can also coincide with a tap pulse. The bench holds one timer on the divide-by-1024 tap for the whole run. A second timer steps through all sixteen select values while pseudo-random events toggle every cycle, and a third timer follows a shifted select value. Every timer is compared in every cycle against an arithmetic model driven only by the bench's own count of edges since reset release. Any disturbance of the shared phase, or leakage between the event and tap paths, shows up as a mismatch.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned N_TAPS = 7;
  localparam int unsigned N_EVT  = 2 ** (SEL_W - 1);

  typedef logic [SEL_W-1:0] csel_t;

  localparam csel_t SEL_OFF = '0;

  // log2 of the divide ratio for each tap, tap 0 = divide by 1
  function automatic int unsigned tap_shift(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 3;
      4:       return 6;
      5:       return 8;
      default: return 10;
    endcase
  endfunction

  localparam int unsigned PRE_W = tap_shift(N_TAPS - 1);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [N_TAPS-1:0] tap_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int unsigned S = tap_shift(i);
    if (S == 0) begin : g_div1
      assign tap_o[i] = 1'b1;
    end else begin : g_divn
      assign tap_o[i] = &cnt_q[S-1:0];
    end
  end
endmodule

// File: rtl/tmr_src_mux.sv
module tmr_src_mux
  import tmr_clk_pkg::*;
(
  input  logic              en_i,
  input  csel_t             sel_i,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic [N_EVT-1:0]  evt_i,
  output logic              tick_o
);
  logic [N_TAPS:0]    tap_pad;
  logic [SEL_W-2:0]   low_sel;
  logic [SEL_W-2:0]   tap_idx;

  assign tap_pad = {1'b0, tap_i};
  assign low_sel = sel_i[SEL_W-2:0];
  assign tap_idx = low_sel - 1'b1;

  always_comb begin
    if (!en_i || sel_i == SEL_OFF) tick_o = 1'b0;
    else if (sel_i[SEL_W-1])       tick_o = evt_i[low_sel];
    else                           tick_o = tap_pad[tap_idx];
  end
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_clk_pkg::*;
#(
  parameter int unsigned N_TIMERS = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_TIMERS*SEL_W-1:0] sel_i,
  input  logic [N_EVT-1:0]          evt_i,
  output logic [N_TIMERS-1:0]       tick_o
);
  logic [N_TAPS-1:0] tap;

  tmr_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_o  (tap)
  );

  for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
    tmr_src_mux u_mux (
      .en_i   (rst_ni),
      .sel_i  (sel_i[t*SEL_W +: SEL_W]),
      .tap_i  (tap),
      .evt_i  (evt_i),
      .tick_o (tick_o[t])
    );
  end
endmodule

// File: rtl/tmr_clk_sel_chk.sv
module tmr_clk_sel_chk
  import tmr_clk_pkg::*;
#(
  parameter int unsigned N_TIMERS = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_TIMERS*SEL_W-1:0] sel_i,
  input logic [N_EVT-1:0]          evt_i,
  input logic [N_TIMERS-1:0]       tick_o
);
  logic [PRE_W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= ref_q + 1'b1;
  end

  function automatic logic ref_tap(input csel_t s, input logic [PRE_W-1:0] c);
    logic [PRE_W-1:0] m;
    m = PRE_W'((1 << tap_shift(32'(s) - 1)) - 1);
    return (c & m) == m;
  endfunction

  for (genvar t = 0; t < N_TIMERS; t++) begin : g_chk
    csel_t s;
    assign s = sel_i[t*SEL_W +: SEL_W];

    // R1
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s == SEL_OFF) |-> !tick_o[t]);

    // R2
    div1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s == csel_t'(1)) |-> tick_o[t]);

    // R3
    tap_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s >= csel_t'(2) && !s[SEL_W-1]) |-> (tick_o[t] == ref_tap(s, ref_q)));

    // R5
    evt_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s[SEL_W-1] |-> (tick_o[t] == evt_i[s[SEL_W-2:0]]));

    // R9
    div2_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s == csel_t'(2) && tick_o[t]) |=> (sel_i[t*SEL_W +: SEL_W] != csel_t'(2) || !tick_o[t]));
  end
endmodule

bind tmr_clk_sel tmr_clk_sel_chk #(.N_TIMERS(N_TIMERS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .evt_i  (evt_i),
  .tick_o (tick_o)
);

// File: tb/sim_tmr_clk_sel.sv
module sim_tmr_clk_sel;
  import tmr_clk_pkg::*;

  localparam int NT = 3;
  localparam int NE = N_EVT;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NT*4-1:0]   sel = '0;
  logic [NE-1:0]     evt = '0;
  logic [NT-1:0]     tick;
  int                n_tests = 0;
  int                n_fail = 0;
  int unsigned       cyc;
  logic [15:0]       lfsr = 16'hACE1;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  tmr_clk_sel #(.N_TIMERS(NT)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sel_i  (sel),
    .evt_i  (evt),
    .tick_o (tick)
  );

  function automatic int div_log(input int s);
    case (s)
      1: return 0;
      2: return 1;
      3: return 2;
      4: return 3;
      5: return 6;
      6: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic exp_tick(input int s, input int unsigned c, input logic [NE-1:0] e);
    int d;
    if (s == 0) return 1'b0;
    if (s >= 8) return e[s-8];
    d = 1 << div_log(s);
    return (c % d) == d - 1;
  endfunction

  function automatic string req_of(input int s);
    if (s == 0) return "R1";
    if (s == 1) return "R2";
    if (s < 8)  return "R3";
    return "R5";
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s cyc=%0d got=%0b exp=%0b", req, what, cyc, got, exp);
    end
  endtask

  task automatic set_sel(input int t, input int s);
    sel[t*4 +: 4] = 4'(s);
  endtask

  // drive events at negedge, compare all timers mid low phase
  task automatic cycle_chk(input logic [NE-1:0] e);
    @(negedge clk);
    evt = e;
    #4;
    for (int t = 0; t < NT; t++) begin
      int s;
      string rq;
      s  = int'(sel[t*4 +: 4]);
      rq = (t == 1) ? "R4" : (t == 2) ? "R7" : req_of(s);
      check(tick[t], exp_tick(s, cyc, e), rq, $sformatf("timer%0d sel=%0d", t, s));
    end
  endtask

  task automatic rnd_cycle();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cycle_chk(lfsr[NE-1:0]);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int first;
    int cnt0;
    int cnt2;
    // R8: reset holds every tick low even with divide-by-1 and live events
    set_sel(0, 1); set_sel(1, 7); set_sel(2, 8);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); evt = '1; #4;
      check(tick != '0 ? 1'b1 : 1'b0, 1'b0, "R8", "ticks during reset");
    end
    @(negedge clk);
    rst_n = 1'b1;
    evt = '0;

    // sweep every select on timer 0, timer 1 fixed on divide-by-1024
    for (int s = 0; s < 16; s++) begin
      int len;
      set_sel(0, s);
      set_sel(2, (s + 5) % 16);
      len = (s >= 2 && s < 8) ? 2 * (1 << div_log(s)) + 10 : 60;
      for (int i = 0; i < len; i++) rnd_cycle();
    end

    // R6: only the chosen channel matters
    for (int k = 0; k < NE; k++) begin
      set_sel(0, 8 + k);
      @(negedge clk); evt = ~(NE'(1) << k); #4;
      check(tick[0], 1'b0, "R6", $sformatf("others high, ch%0d low", k));
      @(negedge clk); evt = NE'(1) << k; #4;
      check(tick[0], 1'b1, "R6", $sformatf("only ch%0d high", k));
    end

    // R8 / R9: reset again, then count ticks over one full prescaler period
    @(negedge clk);
    rst_n = 1'b0;
    evt = '0;
    set_sel(0, 5); set_sel(2, 4);
    #4;
    check(tick != '0 ? 1'b1 : 1'b0, 1'b0, "R8", "ticks during second reset");
    @(negedge clk);
    rst_n = 1'b1;
    first = -1; cnt0 = 0; cnt2 = 0;
    for (int i = 1; i <= 1024; i++) begin
      cycle_chk('0);
      if (tick[1] && first < 0) first = i;
      if (tick[0]) cnt0++;
      if (tick[2]) cnt2++;
    end
    n_tests++;
    if (first != 1023) begin
      n_fail++;
      $display("FAIL R8 first div1024 tick got=%0d exp=1023", first);
    end
    n_tests++;
    if (cnt0 != 16) begin
      n_fail++;
      $display("FAIL R9 div64 ticks got=%0d exp=16", cnt0);
    end
    n_tests++;
    if (cnt2 != 128) begin
      n_fail++;
      $display("FAIL R9 div8 ticks got=%0d exp=128", cnt2);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule